// File: doc/BRIEF.md
# Privileged Status and Trap Controller

This block keeps the machine status word and the trap-handling control registers of a small RISC-style core. The pipeline uses a narrow CSR port to read and write them. It drives per-line set and clear pulses into the pending-interrupt field, and raises a trap request that carries a cause, the faulting PC and an optional bad address. The block answers with a PC redirect, with the current privilege and width mode, and with an interrupt-take request and the cause the pipeline should trap with.

A three-state sequencer drives the redirect output. `ST_BOOT` is held through reset and presents the boot PC 0x2000 for one cycle after reset is released. `ST_RUN` is the idle state and presents no redirect. `ST_REDIR` presents the trap vector for the one cycle after a trap is accepted. The transitions are as follows. A trap moves any state to `ST_REDIR`, and this includes a trap arriving while the sequencer is already in `ST_REDIR`. With no trap, `ST_BOOT` moves to `ST_RUN` and `ST_REDIR` moves to `ST_RUN`, while `ST_RUN` stays in `ST_RUN`.

Status word layout (XLEN=64, 8 interrupt lines):
- bit 0 SUP: supervisor mode.
- bit 1 PSUP: previous supervisor.
- bit 2 IE: global interrupt enable.
- bit 3 PIE: previous IE.
- bit 4 S64: 64-bit supervisor mode.
- bit 5 U64: 64-bit user mode.
- bit 6 VM: translation enable.
- bits 15:8 IM: interrupt mask.
- bits 23:16 IP: interrupt pending.
- All other bits are reserved and read as zero.

Top module: `priv_trap_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, redirect_vld is 1 and redirect_pc is 0x2000. The sequencer then moves to ST_RUN and redirect_vld drops to 0. Status resets to 0x31 (SUP, S64 and U64 set). All other registers reset to zero.
- R2: irq_take is 1 only when IE (status bit 2) is 1 and (IP & IM) is nonzero.
- R3: When several lines are pending and enabled, the lowest index wins. irq_cause equals that index plus a flag bit.
- R4: The flag bit of irq_cause is bit 63 when S64 (status bit 4) is 1, and bit 31 otherwise.
- R5: A trap sets SUP and clears IE. In the same update it copies the old SUP into PSUP (bit 1) and the old IE into PIE (bit 3).
- R6: A trap records trap_cause in the cause register and trap_pc in the saved PC. It records trap_tval in the bad-address register only when trap_tval_vld is 1. In the next cycle redirect_vld is 1 and redirect_pc equals the trap vector.
- R7: A CSR write to status leaves the IP field unchanged and forces the reserved bits to zero.
- R8: A write to the trap vector clears its two low bits.
- R9: A write to the to-host mailbox takes effect only while the mailbox holds zero. host_tohost_clr clears it, and tohost_o shows its value.
- R10: Writing a nonzero value to the from-host mailbox sets pending line 6 (status bit 22). Writing zero clears that line.
- R11: mode64 equals S64 while SUP is 1, and U64 (status bit 5) otherwise. priv_sup equals SUP.
- R12: A CSR write in the same cycle as trap_req is discarded.
- R13: CSR addresses are 0 status, 1 saved PC, 2 cause, 3 trap vector, 4 bad address, 5 scratch0, 6 scratch1, 7 to-host, 8 from-host. Saved PC and the scratch registers read back what was written. Cause and bad address ignore CSR writes. A read of any other address sets csr_illegal and returns 0.
- R14: irq_set[i] sets pending line i and irq_clr[i] clears it. When both are asserted together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | AW | CSR address |
| csr_wen | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_ren | input | 1 | CSR read strobe |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_illegal | output | 1 | Read of an unimplemented address |
| irq_set | input | NIRQ | Per-line pending set pulses |
| irq_clr | input | NIRQ | Per-line pending clear pulses |
| trap_req | input | 1 | Trap entry request |
| trap_cause | input | XLEN | Cause to record |
| trap_pc | input | XLEN | Faulting PC to save |
| trap_tval_vld | input | 1 | trap_tval is meaningful |
| trap_tval | input | XLEN | Bad address |
| host_tohost_clr | input | 1 | Host consumed the to-host mailbox |
| tohost_o | output | XLEN | To-host mailbox value |
| redirect_vld | output | 1 | Redirect the fetch PC |
| redirect_pc | output | XLEN | Boot PC or trap vector |
| priv_sup | output | 1 | Supervisor mode |
| mode64 | output | 1 | Active 64-bit width mode |
| irq_take | output | 1 | An enabled interrupt is pending |
| irq_cause | output | XLEN | Cause for the interrupt to take |

## Verification
A corrupted status word shows up combinationally on priv_sup, mode64, irq_take and irq_cause in the same cycle it is stored. A wrong trap update therefore appears at those ports one cycle after trap_req. A wrong saved PC, cause or bad address stays hidden until it is read through the CSR port. The bench reads these back right after each trap. A sequencer stuck outside ST_RUN holds redirect_vld high and is seen in the cycle after the redirect.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int unsigned SB_SUP  = 0;
    localparam int unsigned SB_PSUP = 1;
    localparam int unsigned SB_IE   = 2;
    localparam int unsigned SB_PIE  = 3;
    localparam int unsigned SB_S64  = 4;
    localparam int unsigned SB_U64  = 5;
    localparam int unsigned SB_VM   = 6;
    localparam int unsigned IM_LO   = 8;

    localparam int unsigned CSR_STATUS   = 0;
    localparam int unsigned CSR_EPC      = 1;
    localparam int unsigned CSR_CAUSE    = 2;
    localparam int unsigned CSR_TVEC     = 3;
    localparam int unsigned CSR_BADADDR  = 4;
    localparam int unsigned CSR_SCRATCH0 = 5;
    localparam int unsigned CSR_SCRATCH1 = 6;
    localparam int unsigned CSR_TOHOST   = 7;
    localparam int unsigned CSR_FROMHOST = 8;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_REDIR = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ptc_status.sv
module ptc_status
    import ptc_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned NIRQ     = 8,
    parameter int unsigned HOST_IRQ = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            trap_enter,
    input  logic [NIRQ-1:0] set_i,
    input  logic [NIRQ-1:0] clr_i,
    input  logic            host_wr,
    input  logic            host_nz,
    output logic [XLEN-1:0] status_o
);
    localparam int unsigned IP_LO = IM_LO + NIRQ;
    localparam logic [XLEN-1:0] LOW_MASK  = (XLEN'(1) << (SB_VM + 1)) - XLEN'(1);
    localparam logic [XLEN-1:0] IM_MASK   = ((XLEN'(1) << NIRQ) - XLEN'(1)) << IM_LO;
    localparam logic [XLEN-1:0] WR_MASK   = LOW_MASK | IM_MASK;
    localparam logic [XLEN-1:0] RST_VAL   = (XLEN'(1) << SB_SUP) | (XLEN'(1) << SB_S64)
                                          | (XLEN'(1) << SB_U64);

    logic [XLEN-1:0] stat_q, stat_d;
    logic [NIRQ-1:0] ip_d;

    always_comb begin
        stat_d = stat_q;
        if (trap_enter) begin
            stat_d[SB_PSUP] = stat_q[SB_SUP];
            stat_d[SB_PIE]  = stat_q[SB_IE];
            stat_d[SB_SUP]  = 1'b1;
            stat_d[SB_IE]   = 1'b0;
        end else if (wr_en) begin
            stat_d = wr_data & WR_MASK;
        end
        ip_d = (stat_q[IP_LO +: NIRQ] & ~clr_i) | set_i;
        if (host_wr) begin
            ip_d[HOST_IRQ] = host_nz;
        end
        stat_d[IP_LO +: NIRQ] = ip_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= RST_VAL;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;

    assert_trap_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (stat_q[SB_SUP] && !stat_q[SB_IE]
                        && stat_q[SB_PSUP] == $past(stat_q[SB_SUP])
                        && stat_q[SB_PIE] == $past(stat_q[SB_IE])));

    assert_ip_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_enter && set_i == '0 && clr_i == '0 && !host_wr)
        |=> $stable(stat_q[IP_LO +: NIRQ]));

    assert_set_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q[IP_LO +: NIRQ] & $past(set_i)) == $past(set_i)
                           || $past(host_wr)));
endmodule

// File: rtl/ptc_irq_sel.sv
module ptc_irq_sel #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] ip_i,
    input  logic [NIRQ-1:0] im_i,
    input  logic            ie_i,
    input  logic            s64_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int unsigned IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam logic [XLEN-1:0] FLAG64 = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] FLAG32 = XLEN'(1) << 31;

    logic [NIRQ-1:0] live;
    logic [IW-1:0]   idx;

    assign live = ip_i & im_i;

    always_comb begin
        idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (live[i]) idx = IW'(i);
        end
    end

    assign take_o  = ie_i && (live != '0);
    assign cause_o = XLEN'(idx) | (s64_i ? FLAG64 : FLAG32);

    assert_take_needs_ie_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (ie_i && ip_i[idx] && im_i[idx]));

    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((ip_i & im_i & ((NIRQ'(1) << idx) - NIRQ'(1))) == '0));
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs #(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] wdata,
    input  logic            we_epc,
    input  logic            we_tvec,
    input  logic            we_scr0,
    input  logic            we_scr1,
    input  logic            we_tohost,
    input  logic            we_fromhost,
    input  logic            trap_enter,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            trap_tval_vld,
    input  logic [XLEN-1:0] trap_tval,
    input  logic            tohost_clr,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] badaddr_o,
    output logic [XLEN-1:0] scr0_o,
    output logic [XLEN-1:0] scr1_o,
    output logic [XLEN-1:0] tohost_o,
    output logic [XLEN-1:0] fromhost_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o      <= '0;
            cause_o    <= '0;
            tvec_o     <= '0;
            badaddr_o  <= '0;
            scr0_o     <= '0;
            scr1_o     <= '0;
            tohost_o   <= '0;
            fromhost_o <= '0;
        end else begin
            if (trap_enter) begin
                epc_o   <= trap_pc;
                cause_o <= trap_cause;
                if (trap_tval_vld) badaddr_o <= trap_tval;
            end else if (we_epc) begin
                epc_o <= wdata;
            end
            if (we_tvec)     tvec_o     <= wdata & ALIGN_MASK;
            if (we_scr0)     scr0_o     <= wdata;
            if (we_scr1)     scr1_o     <= wdata;
            if (we_fromhost) fromhost_o <= wdata;
            if (tohost_clr)                        tohost_o <= '0;
            else if (we_tohost && tohost_o == '0)  tohost_o <= wdata;
        end
    end

    assert_tvec_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tvec_o[1:0] == 2'b00);

    assert_tohost_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tohost_o != '0 && !tohost_clr) |=> $stable(tohost_o));
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
    import ptc_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned NIRQ     = 8,
    parameter int unsigned HOST_IRQ = 6,
    parameter int unsigned AW       = 5,
    parameter logic [63:0] BOOT_PC  = 64'h2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   csr_addr,
    input  logic            csr_wen,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_ren,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic [NIRQ-1:0] irq_set,
    input  logic [NIRQ-1:0] irq_clr,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            trap_tval_vld,
    input  logic [XLEN-1:0] trap_tval,
    input  logic            host_tohost_clr,
    output logic [XLEN-1:0] tohost_o,
    output logic            redirect_vld,
    output logic [XLEN-1:0] redirect_pc,
    output logic            priv_sup,
    output logic            mode64,
    output logic            irq_take,
    output logic [XLEN-1:0] irq_cause
);
    localparam int unsigned IP_LO = IM_LO + NIRQ;

    seq_state_e state_q, state_d;

    logic            wr_ok;
    logic [XLEN-1:0] status;
    logic [XLEN-1:0] epc, cause, tvec, badaddr, scr0, scr1, fromhost;

    // CSR writes lose to a trap in the same cycle (R12)
    assign wr_ok = csr_wen && !trap_req;

    function automatic logic hit(input logic [AW-1:0] a, input int unsigned n);
        return a == AW'(n);
    endfunction

    ptc_status #(.XLEN(XLEN), .NIRQ(NIRQ), .HOST_IRQ(HOST_IRQ)) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok && hit(csr_addr, CSR_STATUS)),
        .wr_data    (csr_wdata),
        .trap_enter (trap_req),
        .set_i      (irq_set),
        .clr_i      (irq_clr),
        .host_wr    (wr_ok && hit(csr_addr, CSR_FROMHOST)),
        .host_nz    (csr_wdata != '0),
        .status_o   (status)
    );

    ptc_irq_sel #(.XLEN(XLEN), .NIRQ(NIRQ)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ip_i    (status[IP_LO +: NIRQ]),
        .im_i    (status[IM_LO +: NIRQ]),
        .ie_i    (status[SB_IE]),
        .s64_i   (status[SB_S64]),
        .take_o  (irq_take),
        .cause_o (irq_cause)
    );

    ptc_regs #(.XLEN(XLEN)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdata         (csr_wdata),
        .we_epc        (wr_ok && hit(csr_addr, CSR_EPC)),
        .we_tvec       (wr_ok && hit(csr_addr, CSR_TVEC)),
        .we_scr0       (wr_ok && hit(csr_addr, CSR_SCRATCH0)),
        .we_scr1       (wr_ok && hit(csr_addr, CSR_SCRATCH1)),
        .we_tohost     (wr_ok && hit(csr_addr, CSR_TOHOST)),
        .we_fromhost   (wr_ok && hit(csr_addr, CSR_FROMHOST)),
        .trap_enter    (trap_req),
        .trap_cause    (trap_cause),
        .trap_pc       (trap_pc),
        .trap_tval_vld (trap_tval_vld),
        .trap_tval     (trap_tval),
        .tohost_clr    (host_tohost_clr),
        .epc_o         (epc),
        .cause_o       (cause),
        .tvec_o        (tvec),
        .badaddr_o     (badaddr),
        .scr0_o        (scr0),
        .scr1_o        (scr1),
        .tohost_o      (tohost_o),
        .fromhost_o    (fromhost)
    );

    // CSR read mux
    always_comb begin
        csr_rdata   = '0;
        csr_illegal = 1'b0;
        if (csr_ren) begin
            unique case (int'(csr_addr))
                CSR_STATUS:   csr_rdata = status;
                CSR_EPC:      csr_rdata = epc;
                CSR_CAUSE:    csr_rdata = cause;
                CSR_TVEC:     csr_rdata = tvec;
                CSR_BADADDR:  csr_rdata = badaddr;
                CSR_SCRATCH0: csr_rdata = scr0;
                CSR_SCRATCH1: csr_rdata = scr1;
                CSR_TOHOST:   csr_rdata = tohost_o;
                CSR_FROMHOST: csr_rdata = fromhost;
                default:      csr_illegal = 1'b1;
            endcase
        end
    end

    assign priv_sup = status[SB_SUP];
    assign mode64   = status[SB_SUP] ? status[SB_S64] : status[SB_U64];

    // Redirect sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Redirect sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = trap_req ? ST_REDIR : ST_RUN;
            ST_RUN:   state_d = trap_req ? ST_REDIR : ST_RUN;
            ST_REDIR: state_d = trap_req ? ST_REDIR : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // Redirect sequencer: outputs
    always_comb begin
        redirect_vld = 1'b0;
        redirect_pc  = '0;
        unique case (state_q)
            ST_BOOT: begin
                redirect_vld = 1'b1;
                redirect_pc  = XLEN'(BOOT_PC);
            end
            ST_REDIR: begin
                redirect_vld = 1'b1;
                redirect_pc  = tvec;
            end
            default: ;
        endcase
    end

    assert_trap_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (redirect_vld && redirect_pc == tvec && epc == $past(trap_pc)));

    assert_trap_drops_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && csr_wen) |=> (scr0 == $past(scr0) && scr1 == $past(scr1)));

    assert_illegal_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0 && csr_ren));

    assert_boot_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && redirect_pc == XLEN'(BOOT_PC) && !trap_req) |=> (state_q != ST_BOOT));
endmodule

// File: tb/priv_trap_ctrl_tb_top.sv
module priv_trap_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int NIRQ = 8;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   csr_addr = '0;
    logic            csr_wen = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_ren = 1'b0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic [NIRQ-1:0] irq_set = '0;
    logic [NIRQ-1:0] irq_clr = '0;
    logic            trap_req = 1'b0;
    logic [XLEN-1:0] trap_cause = '0;
    logic [XLEN-1:0] trap_pc = '0;
    logic            trap_tval_vld = 1'b0;
    logic [XLEN-1:0] trap_tval = '0;
    logic            host_tohost_clr = 1'b0;
    logic [XLEN-1:0] tohost_o;
    logic            redirect_vld;
    logic [XLEN-1:0] redirect_pc;
    logic            priv_sup;
    logic            mode64;
    logic            irq_take;
    logic [XLEN-1:0] irq_cause;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .csr_addr(csr_addr), .csr_wen(csr_wen), .csr_wdata(csr_wdata),
        .csr_ren(csr_ren), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .irq_set(irq_set), .irq_clr(irq_clr),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
        .trap_tval_vld(trap_tval_vld), .trap_tval(trap_tval),
        .host_tohost_clr(host_tohost_clr), .tohost_o(tohost_o),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .priv_sup(priv_sup), .mode64(mode64),
        .irq_take(irq_take), .irq_cause(irq_cause)
    );

    // {addr, write data, expected read-back}
    localparam logic [132:0] VEC [12] = '{
        {5'd3, 64'h0000_0000_0000_1003, 64'h0000_0000_0000_1000},
        {5'd1, 64'h0000_0000_DEAD_BEEF, 64'h0000_0000_DEAD_BEEF},
        {5'd5, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
        {5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {5'd2, 64'h0000_0000_0000_0077, 64'h0000_0000_0000_0000},
        {5'd4, 64'h0000_0000_0000_0099, 64'h0000_0000_0000_0000},
        {5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FF7F},
        {5'd0, 64'h0000_0000_0000_0031, 64'h0000_0000_0000_0031},
        {5'd7, 64'h0000_0000_0000_00AB, 64'h0000_0000_0000_00AB},
        {5'd7, 64'h0000_0000_0000_00CD, 64'h0000_0000_0000_00AB},
        {5'd8, 64'h0000_0000_0000_0009, 64'h0000_0000_0000_0009},
        {5'd8, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wen = 1'b1;
        @(negedge clk);
        csr_wen = 1'b0;
    endtask

    task automatic csr_rd(input logic [4:0] a, output logic [63:0] d, output logic ill);
        @(negedge clk);
        csr_addr = a; csr_ren = 1'b1;
        #1;
        d = csr_rdata; ill = csr_illegal;
        csr_ren = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        irq_set = s; irq_clr = c;
        @(negedge clk);
        irq_set = '0; irq_clr = '0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic ill;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 boot redirect_vld", 64'(redirect_vld), 64'd1);
        chk("R1 boot redirect_pc", redirect_pc, 64'h2000);
        chk("R1 priv_sup", 64'(priv_sup), 64'd1);
        chk("R11 reset mode64", 64'(mode64), 64'd1);
        chk("R2 reset irq_take", 64'(irq_take), 64'd0);
        @(negedge clk); #1;
        chk("R1 redirect drops", 64'(redirect_vld), 64'd0);
        csr_rd(5'd0, rd, ill); chk("R1 reset status", rd, 64'h31);
        for (int a = 1; a <= 8; a++) begin
            csr_rd(5'(a), rd, ill); chk("R1 reset reg zero", rd, 64'd0);
        end

        // table walk: R7 R8 R9 R13 register behaviour
        for (int i = 0; i < 12; i++) begin
            csr_wr(VEC[i][132:128], VEC[i][127:64]);
            csr_rd(VEC[i][132:128], rd, ill);
            chk($sformatf("R13 table entry %0d", i), rd, VEC[i][63:0]);
        end
        chk("R9 tohost_o holds first value", tohost_o, 64'hAB);

        // R2: pending but IE off
        pulse(8'h04, 8'h00);
        chk("R2 no take with IE=0", 64'(irq_take), 64'd0);
        csr_wr(5'd0, 64'h0435); #1;
        chk("R2 take with IE and mask", 64'(irq_take), 64'd1);
        chk("R4 cause flag bit 63", irq_cause, 64'h8000_0000_0000_0002);

        // R3: lowest index wins
        pulse(8'h20, 8'h00);
        csr_wr(5'd0, 64'h2435); #1;
        chk("R3 lowest index", irq_cause, 64'h8000_0000_0000_0002);
        pulse(8'h00, 8'h04);
        chk("R3 next index", irq_cause, 64'h8000_0000_0000_0005);

        // R4: S64 off
        csr_wr(5'd0, 64'h2425); #1;
        chk("R4 cause flag bit 31", irq_cause, 64'h0000_0000_8000_0005);
        chk("R11 mode64 supervisor S64=0", 64'(mode64), 64'd0);

        // R11: user mode uses U64
        csr_wr(5'd0, 64'h2424); #1;
        chk("R11 priv_sup user", 64'(priv_sup), 64'd0);
        chk("R11 mode64 user U64=1", 64'(mode64), 64'd1);

        // R14: set beats clear
        pulse(8'h20, 8'h20);
        csr_rd(5'd0, rd, ill); chk("R14 set wins", (rd >> 16) & 64'hFF, 64'h20);
        pulse(8'h00, 8'h20);
        chk("R14 clear", 64'(irq_take), 64'd0);

        // R7: IP not writable, reserved zero
        pulse(8'h01, 8'h00);
        csr_wr(5'd0, 64'hFFFF_FFFF_FFFF_2424);
        csr_rd(5'd0, rd, ill); chk("R7 IP kept reserved zero", rd, 64'h0001_2424);
        pulse(8'h00, 8'h01);

        // R5 R6 R12: trap from user mode with IE=1, write in same cycle
        @(negedge clk);
        trap_req = 1'b1; trap_cause = 64'h8; trap_pc = 64'h4444;
        trap_tval_vld = 1'b1; trap_tval = 64'h5555;
        csr_wen = 1'b1; csr_addr = 5'd5; csr_wdata = 64'hBAD;
        @(negedge clk);
        trap_req = 1'b0; trap_tval_vld = 1'b0; csr_wen = 1'b0;
        #1;
        chk("R6 redirect_vld after trap", 64'(redirect_vld), 64'd1);
        chk("R6 redirect_pc is vector", redirect_pc, 64'h1000);
        chk("R5 priv_sup after trap", 64'(priv_sup), 64'd1);
        chk("R11 mode64 after trap", 64'(mode64), 64'd0);
        csr_rd(5'd0, rd, ill); chk("R5 status after trap", rd, 64'h2429);
        chk("R6 redirect one cycle", 64'(redirect_vld), 64'd0);
        csr_rd(5'd1, rd, ill); chk("R6 saved pc", rd, 64'h4444);
        csr_rd(5'd2, rd, ill); chk("R6 cause", rd, 64'h8);
        csr_rd(5'd4, rd, ill); chk("R6 bad address", rd, 64'h5555);
        csr_rd(5'd5, rd, ill); chk("R12 write dropped", rd, 64'h1234_5678_9ABC_DEF0);

        // second trap from supervisor, IE=1, no tval
        csr_wr(5'd0, 64'h0035);
        @(negedge clk);
        trap_req = 1'b1; trap_cause = 64'h3; trap_pc = 64'h7770;
        @(negedge clk);
        trap_req = 1'b0;
        csr_rd(5'd0, rd, ill); chk("R5 status from supervisor", rd, 64'h3B);
        csr_rd(5'd4, rd, ill); chk("R6 tval not valid keeps", rd, 64'h5555);

        // R10: from-host raises line 6
        csr_wr(5'd8, 64'h1);
        csr_rd(5'd0, rd, ill); chk("R10 host pending set", (rd >> 22) & 64'h1, 64'h1);
        csr_wr(5'd8, 64'h0);
        csr_rd(5'd0, rd, ill); chk("R10 host pending clear", (rd >> 22) & 64'h1, 64'h0);

        // R9: host clear then accept new value
        @(negedge clk); host_tohost_clr = 1'b1;
        @(negedge clk); host_tohost_clr = 1'b0; #1;
        chk("R9 tohost cleared", tohost_o, 64'h0);
        csr_wr(5'd7, 64'hCD);
        csr_rd(5'd7, rd, ill); chk("R9 tohost accepts when zero", rd, 64'hCD);

        // R13: unimplemented addresses
        csr_rd(5'd9, rd, ill);
        chk("R13 illegal flag addr 9", 64'(ill), 64'd1);
        chk("R13 illegal data zero", rd, 64'd0);
        csr_rd(5'd31, rd, ill); chk("R13 illegal flag addr 31", 64'(ill), 64'd1);
        csr_rd(5'd0, rd, ill); chk("R13 legal address no flag", 64'(ill), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule